// File: doc/BRIEF.md
# Word-Parallel CRC-32 Engine with Byte Tail

This block folds a stream of 32-bit words into a CRC-32 remainder at one word per clock. The running remainder is XORed with the incoming word, the four resulting bytes each address their own 256-entry constant table, and the XOR of the four table outputs is the next remainder. Each table clears a different byte-wide span of the remainder after it has been moved up by a full word, so no shift or bit-serial step is needed on the main path. The table contents are computed from the polynomial when the design is elaborated.

A frame opens with a start pulse, which loads the remainder with all ones. Words follow on a valid strobe. The last word carries a flag and a byte-enable. A full last word finishes in the same step as any other word. A short last word is finished one byte per clock through the table that sits nearest the remainder. During that time the ready output stays low. A one-cycle done pulse marks the end of the frame, and the inverted remainder is then held on the output until the next start.

Top module: `crc32_slice4`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `crc_o` is 0x00000000.
- R2: A start pulse loads the remainder with all ones. In the following cycle `crc_o` reads 0x00000000 and `done_o` is 0.
- R3: Every word accepted in a frame (`valid_i` high, `ready_o` high, no start) is folded into the reflected CRC-32 with polynomial 0xEDB88320. Byte 0 (`data_i[7:0]`) is the first byte of the word on the wire and bits are taken LSB first. For the bytes "123456789" the final `crc_o` is 0xCBF43926.
- R4: When an accepted last word has all four enable bits set, `done_o` is high in the next cycle. At that point `crc_o` is the bitwise inverse of the remainder over every byte of the frame.
- R5: For an accepted last word, the byte count n is the number of consecutive set bits of `be_i` counted from bit 0 upward. If n is 1 to 3, `ready_o` is low for exactly n cycles after acceptance, and `done_o` rises in the cycle after the n-th byte is absorbed. Enable bits above the first clear bit, and the disabled bytes of `data_i`, have no effect.
- R6: An accepted last word with `be_i[0]` equal to 0 contributes no bytes. `done_o` is high in the next cycle and `crc_o` is unchanged.
- R7: Outside a frame (after done and before the next start), `valid_i` is ignored and `crc_o` holds its value.
- R8: A start pulse takes priority over a word presented in the same cycle and over a byte tail in progress. In the next cycle `ready_o` is 1 and `done_o` is 0.
- R9: `done_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a frame and presets the remainder |
| valid_i | input | 1 | Word present on `data_i` |
| last_i | input | 1 | Present word closes the frame |
| data_i | input | 32 | Input word, byte 0 first on the wire |
| be_i | input | 4 | Byte enables for the last word, contiguous from bit 0 |
| ready_o | output | 1 | Low while the byte tail is being absorbed |
| done_o | output | 1 | One-cycle pulse when the frame result is ready |
| crc_o | output | 32 | Inverted remainder, held after done |

## Verification
The bench aims at frame lengths that are not multiples of four, so that tails of one, two and three bytes all occur. A design with the table spans swapped, or with the byte order inside a word reversed, would produce wrong CRCs on multi-word frames. A design that miscounts the tail would hold ready low for the wrong number of cycles, or pulse done early, and that shows up in the per-cycle comparison. The bench also covers these cases:
- an empty last word, where a design that still absorbs a byte corrupts the result;
- a start that cuts a tail short, where a design that ignores it leaves ready low and raises a stray done;
- words offered outside any frame, where a design that absorbs them changes the held CRC;
- a non-contiguous enable mask, where the bits above the first gap must be ignored.

// File: rtl/crc_s4_pkg.sv
package crc_s4_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } crc_st_e;

   // Remainder that clears byte value b placed (span) bytes beyond the nearest span:
   // the one-byte CRC of b, advanced by 8*span further zero bits.
   function automatic logic [31:0] span_entry(input logic [31:0] poly,
                                              input int span,
                                              input int b);
      logic [31:0] r;
      r = 32'(b);
      for (int s = 0; s < 8 * (span + 1); s++) begin
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_s4_rom.sv
module crc_s4_rom #(
   parameter int          SPAN = 0,
   parameter logic [31:0] POLY = 32'hEDB88320
) (
   input  logic [7:0]  idx_i,
   output logic [31:0] q_o
);
   localparam int ENTRIES = 256;

   if (SPAN < 0 || SPAN > 7) begin : g_bad_span
      $error("crc_s4_rom: SPAN out of range");
   end

   logic [31:0] rom [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam logic [31:0] VAL = crc_s4_pkg::span_entry(POLY, SPAN, e);
      assign rom[e] = VAL;
   end

   assign q_o = rom[idx_i];

endmodule

// File: rtl/crc_s4_fold.sv
module crc_s4_fold #(
   parameter int          LANES = 4,
   parameter logic [31:0] POLY  = 32'hEDB88320
) (
   input  logic [31:0]         rem_i,
   input  logic [8*LANES-1:0]  word_i,
   input  logic                byte_mode_i,
   input  logic [7:0]          byte_i,
   output logic [31:0]         nxt_o
);
   localparam int DW = 8 * LANES;

   logic [31:0] mix;
   logic [31:0] carry;
   logic [7:0]  idx [LANES];
   logic [31:0] q   [LANES];

   assign mix = rem_i ^ 32'(word_i);

   if (DW < 32) begin : g_carry
      assign carry = rem_i >> DW;
   end else begin : g_nocarry
      assign carry = '0;
   end

   // Lane i holds the i-th byte on the wire; the earliest byte needs the widest span.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == LANES - 1) begin : g_near
         assign idx[i] = byte_mode_i ? (rem_i[7:0] ^ byte_i) : mix[8*i +: 8];
      end else begin : g_far
         assign idx[i] = mix[8*i +: 8];
      end
      crc_s4_rom #(
         .SPAN (LANES - 1 - i),
         .POLY (POLY)
      ) u_rom (
         .idx_i (idx[i]),
         .q_o   (q[i])
      );
   end

   always_comb begin
      nxt_o = carry;
      for (int i = 0; i < LANES; i++) begin
         nxt_o = nxt_o ^ q[i];
      end
      if (byte_mode_i) begin
         nxt_o = (rem_i >> 8) ^ q[LANES-1];
      end
   end

endmodule

// File: rtl/crc32_slice4.sv
module crc32_slice4 #(
   parameter int          LANES  = 4,
   parameter logic [31:0] POLY   = 32'hEDB88320,
   parameter logic [31:0] INIT   = 32'hFFFFFFFF,
   parameter logic [31:0] XOROUT = 32'hFFFFFFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                valid_i,
   input  logic                last_i,
   input  logic [8*LANES-1:0]  data_i,
   input  logic [LANES-1:0]    be_i,
   output logic                ready_o,
   output logic                done_o,
   output logic [31:0]         crc_o
);
   import crc_s4_pkg::*;

   localparam int DW = 8 * LANES;
   localparam int CW = $clog2(LANES + 1);

   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("crc32_slice4: LANES must be 1 to 4");
   end

   crc_st_e        st_q;
   logic [31:0]    rem_q;
   logic           done_q;
   logic [DW-1:0]  tbuf_q;
   logic [CW-1:0]  tcnt_q;
   logic [31:0]    rem_nxt;
   logic [CW-1:0]  nlead;
   logic           in_tail;
   logic           take;

   function automatic logic [CW-1:0] lead_ones(input logic [LANES-1:0] m);
      logic [CW-1:0] n;
      logic          run;
      n   = '0;
      run = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         run = run & m[i];
         if (run) n = n + 1'b1;
      end
      return n;
   endfunction

   assign nlead   = lead_ones(be_i);
   assign in_tail = (st_q == ST_TAIL);
   assign take    = valid_i && (st_q == ST_RUN) && !start_i;

   crc_s4_fold #(
      .LANES (LANES),
      .POLY  (POLY)
   ) u_fold (
      .rem_i       (rem_q),
      .word_i      (data_i),
      .byte_mode_i (in_tail),
      .byte_i      (tbuf_q[7:0]),
      .nxt_o       (rem_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= INIT;
         done_q <= 1'b0;
         tbuf_q <= '0;
         tcnt_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            rem_q <= INIT;
            st_q  <= ST_RUN;
         end else begin
            case (st_q)
               ST_RUN: begin
                  if (valid_i) begin
                     if (!last_i || nlead == CW'(LANES)) begin
                        rem_q <= rem_nxt;
                        if (last_i) begin
                           st_q   <= ST_IDLE;
                           done_q <= 1'b1;
                        end
                     end else if (nlead == '0) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        st_q   <= ST_TAIL;
                        tbuf_q <= data_i;
                        tcnt_q <= nlead;
                     end
                  end
               end
               ST_TAIL: begin
                  rem_q  <= rem_nxt;
                  tbuf_q <= tbuf_q >> 8;
                  tcnt_q <= tcnt_q - 1'b1;
                  if (tcnt_q == CW'(1)) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ready_o = !in_tail;
   assign done_o  = done_q;
   assign crc_o   = rem_q ^ XOROUT;

   assert_start_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (crc_o == (INIT ^ XOROUT)));

   assert_full_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_i && (&be_i)) |=> done_o);

   assert_tail_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_i && be_i[0] && !(&be_i)) |=> !ready_o);

   assert_empty_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_i && !be_i[0]) |=> (done_o && $stable(crc_o)));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !start_i) |=> ($stable(crc_o) && ready_o));

   assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (ready_o && !done_o));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/sim_crc32_slice4.sv
module sim_crc32_slice4;
   localparam logic [31:0] POLY = 32'hEDB88320;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        valid_i = 1'b0;
   logic        last_i = 1'b0;
   logic [31:0] data_i = '0;
   logic [3:0]  be_i = '0;
   logic        ready_o, done_o;
   logic [31:0] crc_o;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   crc32_slice4 u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
      .last_i(last_i), .data_i(data_i), .be_i(be_i),
      .ready_o(ready_o), .done_o(done_o), .crc_o(crc_o)
   );

   function automatic logic [31:0] ser_byte(input logic [31:0] r, input logic [7:0] b);
      logic [31:0] x;
      x = r;
      for (int i = 0; i < 8; i++) begin
         x = x ^ 32'(b[i]);
         x = x[0] ? ((x >> 1) ^ POLY) : (x >> 1);
      end
      return x;
   endfunction

   function automatic int lead(input logic [3:0] m);
      int n;
      n = 0;
      for (int i = 0; i < 4; i++) begin
         if (!m[i]) break;
         n++;
      end
      return n;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   int          m_st = 0;  // 0 idle, 1 in frame, 2 tail
   logic [31:0] m_rem = '1;
   bit          m_done = 1'b0;
   logic [7:0]  tq[$];

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_rem = '1; m_done = 1'b0; tq.delete();
      end else begin
         m_done = 1'b0;
         if (start_i) begin
            m_rem = '1; m_st = 1; tq.delete();
         end else if (m_st == 2) begin
            m_rem = ser_byte(m_rem, tq.pop_front());
            if (tq.size() == 0) begin m_st = 0; m_done = 1'b1; end
         end else if (m_st == 1 && valid_i) begin
            int n;
            n = last_i ? lead(be_i) : 4;
            if (n == 4 || n == 0) begin
               for (int i = 0; i < n; i++) m_rem = ser_byte(m_rem, data_i[8*i +: 8]);
               if (last_i) begin m_st = 0; m_done = 1'b1; end
            end else begin
               for (int i = 0; i < n; i++) tq.push_back(data_i[8*i +: 8]);
               m_st = 2;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(ready_o == (m_st != 2), "R5 ready", 32'(ready_o), 32'(m_st != 2));
         chk(done_o == m_done, "R4 done", 32'(done_o), 32'(m_done));
         chk(crc_o == ~m_rem, "R3 crc", crc_o, ~m_rem);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual %0d expected below 150000", cyc);
         finish_run();
      end
   end

   task automatic send_bytes(input logic [7:0] bq[$], input bit gappy, input bit chk_known,
                             input logic [31:0] known);
      int len, nw, k;
      logic [31:0] exp;
      len = bq.size();
      exp = '1;
      foreach (bq[i]) exp = ser_byte(exp, bq[i]);
      exp = ~exp;
      nw = (len + 3) / 4;
      if (nw == 0) nw = 1;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(crc_o == 32'h0 && !done_o, "R2 preset", crc_o, 32'h0);
      for (int w = 0; w < nw; w++) begin
         if (gappy && ($urandom % 3 == 0)) begin
            valid_i = 1'b0; @(negedge clk);
         end
         k = len - 4 * w;
         data_i = $urandom;
         for (int b = 0; b < 4; b++) if (b < k) data_i[8*b +: 8] = bq[4*w + b];
         valid_i = 1'b1;
         last_i = (w == nw - 1);
         be_i = (w == nw - 1) ? ((k >= 4) ? 4'hF : 4'((1 << k) - 1)) : 4'($urandom);
         @(negedge clk);
      end
      valid_i = 1'b0; last_i = 1'b0;
      for (int t = 0; t < 8 && !done_o; t++) @(negedge clk);
      chk(done_o == 1'b1, "R4 done seen", 32'(done_o), 32'h1);
      chk(crc_o == exp, "R3 frame crc", crc_o, exp);
      if (chk_known) chk(crc_o == known, "R3 check value", crc_o, known);
   endtask

   initial begin
      logic [7:0] bq[$];
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(ready_o && !done_o && crc_o == 32'h0, "R1 reset", crc_o, 32'h0);

      // R3 standard check string
      bq = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      send_bytes(bq, 1'b0, 1'b1, 32'hCBF43926);

      // R7 words offered outside a frame are ignored
      held = crc_o;
      valid_i = 1'b1; last_i = 1'b1; be_i = 4'hF; data_i = 32'hDEADBEEF;
      repeat (3) @(negedge clk);
      chk(crc_o == held && !done_o, "R7 idle hold", crc_o, held);
      valid_i = 1'b0; last_i = 1'b0;

      // R6 empty last word
      bq.delete();
      send_bytes(bq, 1'b0, 1'b1, 32'h0);

      // R5 non-contiguous mask counts only the leading run
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      valid_i = 1'b1; last_i = 1'b1; be_i = 4'b0101; data_i = 32'h11223344;
      @(negedge clk); valid_i = 1'b0; last_i = 1'b0;
      chk(!ready_o, "R5 tail ready", 32'(ready_o), 32'h0);
      @(negedge clk);
      chk(done_o && crc_o == ~ser_byte(32'hFFFFFFFF, 8'h44), "R5 one byte", crc_o,
          ~ser_byte(32'hFFFFFFFF, 8'h44));

      // R8 start with a word in the same cycle, then start during a tail
      @(negedge clk); start_i = 1'b1; valid_i = 1'b1; last_i = 1'b1; be_i = 4'hF;
      @(negedge clk); start_i = 1'b0;
      chk(!done_o && ready_o && crc_o == 32'h0, "R8 start over word", crc_o, 32'h0);
      be_i = 4'b0111; data_i = 32'hA5A5A5A5;
      @(negedge clk); valid_i = 1'b0; last_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(ready_o && !done_o, "R8 start over tail", 32'(ready_o), 32'h1);
      repeat (4) @(negedge clk);
      chk(!done_o && crc_o == 32'h0, "R8 no stray done", crc_o, 32'h0);

      // random frames of 1 to 64 bytes
      for (int f = 0; f < 60; f++) begin
         int len;
         len = (f < 4) ? (f + 1) : (1 + int'($urandom % 64));
         bq.delete();
         for (int i = 0; i < len; i++) bq.push_back(8'($urandom));
         send_bytes(bq, f[0], 1'b0, 32'h0);
         if (f % 7 == 0) @(negedge clk);
      end

      // R9 is checked every cycle by the model's done comparison
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule